// File: doc/BRIEF.md
# Color Palette Pixel Pipeline

This block turns the pixel stream of a display controller into 8-bit red, green and blue codes for a triple video DAC. It runs on the pixel clock. Each rising edge captures one pixel word and the active-low blank input. The color result leaves three registers later, and the blank signal is delayed by exactly the same amount.

In indexed mode the low byte of the pixel word is ANDed with a pixel mask and used as the address into a 256-entry palette. Each palette entry holds 6 bits per channel, and the block widens each channel to 8 bits. Three direct-color modes skip the palette and unpack the pixel word itself: 5-5-5, 5-6-5, and 8-8-8. In 8-8-8 mode one color is sent over two consecutive pixel words. The host writes palette entries and the mask through a separate write port that is clocked by the same pixel clock. Writes are accepted at any time, including while the display is blanked.

Top module: `pal_pixel_pipe`

## Requirements
- R1: Reset is asynchronous and active low. While reset is held, and until new data has passed through the pipeline, `blank_n_out` is 0 and all three color outputs are 0. The pixel mask resets to all ones.
- R2: A pixel word and blank value sampled at rising edge n appear at the outputs after rising edge n+2 (three register stages).
- R3: When `pix_mode` is 0 (indexed), the palette address is `pix_in[7:0] & mask`. An entry holds red in bits 17:12, green in bits 11:6 and blue in bits 5:0. Each output channel is its 6-bit field followed by two zero bits.
- R4: In indexed mode, `pix_in[15:8]` has no effect on the outputs.
- R5: A host write with `host_sel`=1 loads `host_wdata[7:0]` into the pixel mask. Later lookups use the new mask.
- R6: A host write with `host_sel`=0 loads `host_wdata` into the palette entry at `host_addr`. The write takes effect whether or not the display is blanked.
- R7: When `pix_mode` is 1 (5-5-5), red is `pix_in[14:10]`, green is `pix_in[9:5]` and blue is `pix_in[4:0]`, each followed by three zero bits. `pix_in[15]` is ignored.
- R8: When `pix_mode` is 2 (5-6-5), red is `pix_in[15:11]` followed by three zeros, green is `pix_in[10:5]` followed by two zeros, and blue is `pix_in[4:0]` followed by three zeros.
- R9: When `pix_mode` is 3 (8-8-8), consecutive unblanked words form pairs. The first word of a pair carries green in bits 15:8 and blue in bits 7:0. The second word carries red in bits 7:0, and its output slot shows the complete color. The output slot of a first word repeats the most recent direct-color result.
- R10: Pairing restarts with a first word after any captured word that is blanked or not in mode 3.
- R11: While the delayed blank (`blank_n_out`) is 0, all color outputs are 0, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_mode | input | 2 | Pixel format: 0 indexed, 1 5-5-5, 2 5-6-5, 3 8-8-8 |
| pix_in | input | 16 | Pixel word |
| blank_n_in | input | 1 | Active-low blank, captured with the pixel |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | Write target: 0 palette entry, 1 pixel mask |
| host_addr | input | 8 | Palette entry address |
| host_wdata | input | 18 | Palette entry {R6,G6,B6}, or mask in bits 7:0 |
| red_out | output | 8 | Red DAC code |
| grn_out | output | 8 | Green DAC code |
| blu_out | output | 8 | Blue DAC code |
| blank_n_out | output | 1 | Blank delayed to line up with the colors |

## Verification
On every cycle, the assertions check the behaviours that depend only on the block's ports. These are: the three-cycle alignment of the blank, the zero colors while blanked, the zero outputs during reset, and the field unpacking of the 5-5-5 and 5-6-5 formats. Some behaviours depend on stored state and can only be shown by the bench scenarios. These are: palette contents after host writes, the effect of the mask, the 8-8-8 pairing with its held first-word slot and its restart after a blank or a mode change, and the fact that the upper index byte is ignored. The bench sweeps every palette index under several masks, and uses arithmetic patterns for the direct-color formats.

// File: rtl/pal_pkg.sv
package pal_pkg;

   typedef enum logic [1:0] {
      PM_INDEXED = 2'd0,
      PM_RGB555  = 2'd1,
      PM_RGB565  = 2'd2,
      PM_RGB888  = 2'd3
   } pix_mode_e;

   localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/pal_ram.sv
module pal_ram #(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned ENTRY_W = 18
) (
   input  logic               clk,
   input  logic               we,
   input  logic [ADDR_W-1:0]  waddr,
   input  logic [ENTRY_W-1:0] wdata,
   input  logic [ADDR_W-1:0]  raddr,
   output logic [ENTRY_W-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [ENTRY_W-1:0] mem [DEPTH];

   // write port: host side
   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   // registered read port: pipeline stage 2
   always_ff @(posedge clk) begin
      rdata <= mem[raddr];
   end

endmodule

// File: rtl/pal_bypass_unpack.sv
module pal_bypass_unpack
   import pal_pkg::*;
#(
   parameter int unsigned PIX_W = 16,
   parameter int unsigned DAC_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  pix_mode_e          mode,
   input  logic [PIX_W-1:0]   pix,
   input  logic               second_half,
   output logic [3*DAC_W-1:0] rgb
);

   localparam int unsigned PAD5 = DAC_W - 5;
   localparam int unsigned PAD6 = DAC_W - 6;

   logic [15:0]        gb_q;
   logic [3*DAC_W-1:0] rgb_q;
   logic [DAC_W-1:0]   r888, g888, b888;

   generate
      if (DAC_W == 8) begin : g_w8
         assign r888 = pix[7:0];
         assign g888 = gb_q[15:8];
         assign b888 = gb_q[7:0];
      end else begin : g_wide
         assign r888 = {pix[7:0],    {(DAC_W-8){1'b0}}};
         assign g888 = {gb_q[15:8],  {(DAC_W-8){1'b0}}};
         assign b888 = {gb_q[7:0],   {(DAC_W-8){1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gb_q  <= '0;
         rgb_q <= '0;
      end else begin
         unique case (mode)
            PM_RGB555: rgb_q <= {pix[14:10], {PAD5{1'b0}},
                                 pix[9:5],   {PAD5{1'b0}},
                                 pix[4:0],   {PAD5{1'b0}}};
            PM_RGB565: rgb_q <= {pix[15:11], {PAD5{1'b0}},
                                 pix[10:5],  {PAD6{1'b0}},
                                 pix[4:0],   {PAD5{1'b0}}};
            PM_RGB888: begin
               if (second_half) begin
                  rgb_q <= {r888, g888, b888};
               end else begin
                  gb_q <= pix[15:0];
               end
            end
            default: ; // indexed: direct-color result holds
         endcase
      end
   end

   assign rgb = rgb_q;

endmodule

// File: rtl/pal_out_stage.sv
module pal_out_stage
   import pal_pkg::*;
#(
   parameter int unsigned PAL_W = 6,
   parameter int unsigned DAC_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  pix_mode_e          mode,
   input  logic               blank_n,
   input  logic [3*PAL_W-1:0] entry,
   input  logic [3*DAC_W-1:0] direct_rgb,
   output logic [3*DAC_W-1:0] rgb,
   output logic               blank_n_q
);

   localparam int unsigned NCH = 3;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) blank_n_q <= 1'b0;
      else        blank_n_q <= blank_n;
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int unsigned PSLOT = (NCH - 1 - c) * PAL_W;
      localparam int unsigned DSLOT = (NCH - 1 - c) * DAC_W;
      logic [DAC_W-1:0] widened;
      logic [DAC_W-1:0] ch_q;

      if (DAC_W == PAL_W) begin : g_same
         assign widened = entry[PSLOT +: PAL_W];
      end else begin : g_pad
         assign widened = {entry[PSLOT +: PAL_W], {(DAC_W-PAL_W){1'b0}}};
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        ch_q <= '0;
         else if (!blank_n) ch_q <= '0;
         else if (mode == PM_INDEXED) ch_q <= widened;
         else               ch_q <= direct_rgb[DSLOT +: DAC_W];
      end

      assign rgb[DSLOT +: DAC_W] = ch_q;
   end

endmodule

// File: rtl/pal_pixel_pipe.sv
module pal_pixel_pipe
   import pal_pkg::*;
#(
   parameter int unsigned IDX_W = 8,
   parameter int unsigned PAL_W = 6,
   parameter int unsigned DAC_W = 8,
   parameter int unsigned PIX_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [MODE_W-1:0]    pix_mode,
   input  logic [PIX_W-1:0]     pix_in,
   input  logic                 blank_n_in,
   input  logic                 host_we,
   input  logic                 host_sel,
   input  logic [IDX_W-1:0]     host_addr,
   input  logic [3*PAL_W-1:0]   host_wdata,
   output logic [DAC_W-1:0]     red_out,
   output logic [DAC_W-1:0]     grn_out,
   output logic [DAC_W-1:0]     blu_out,
   output logic                 blank_n_out
);

   localparam int unsigned ENTRY_W = 3 * PAL_W;

   if (PIX_W != 16) begin : g_bad_pix
      $error("pal_pixel_pipe: PIX_W must be 16");
   end
   if (DAC_W < 8 || DAC_W < PAL_W) begin : g_bad_dac
      $error("pal_pixel_pipe: DAC_W must be at least 8 and at least PAL_W");
   end
   if (IDX_W > PIX_W || IDX_W > ENTRY_W) begin : g_bad_idx
      $error("pal_pixel_pipe: IDX_W too wide");
   end

   // stage 1: capture
   pix_mode_e        s1_mode;
   logic [PIX_W-1:0] s1_pix;
   logic             s1_blank_n;
   logic             s1_second;
   logic             pair_second_q;
   logic [IDX_W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_mode       <= PM_INDEXED;
         s1_pix        <= '0;
         s1_blank_n    <= 1'b0;
         s1_second     <= 1'b0;
         pair_second_q <= 1'b0;
      end else begin
         s1_mode    <= pix_mode_e'(pix_mode);
         s1_pix     <= pix_in;
         s1_blank_n <= blank_n_in;
         if (pix_mode_e'(pix_mode) == PM_RGB888 && blank_n_in) begin
            s1_second     <= pair_second_q;
            pair_second_q <= ~pair_second_q;
         end else begin
            s1_second     <= 1'b0;
            pair_second_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   mask_q <= '1;
      else if (host_we && host_sel) mask_q <= host_wdata[IDX_W-1:0];
   end

   // stage 2: palette read and direct-color unpack
   pix_mode_e          s2_mode;
   logic               s2_blank_n;
   logic [ENTRY_W-1:0] s2_entry;
   logic [3*DAC_W-1:0] s2_direct;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_mode    <= PM_INDEXED;
         s2_blank_n <= 1'b0;
      end else begin
         s2_mode    <= s1_mode;
         s2_blank_n <= s1_blank_n;
      end
   end

   pal_ram #(
      .ADDR_W (IDX_W),
      .ENTRY_W(ENTRY_W)
   ) u_ram (
      .clk  (clk),
      .we   (host_we && !host_sel),
      .waddr(host_addr),
      .wdata(host_wdata),
      .raddr(s1_pix[IDX_W-1:0] & mask_q),
      .rdata(s2_entry)
   );

   pal_bypass_unpack #(
      .PIX_W(PIX_W),
      .DAC_W(DAC_W)
   ) u_unpack (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (s1_mode),
      .pix        (s1_pix),
      .second_half(s1_second),
      .rgb        (s2_direct)
   );

   // stage 3: select, blank, drive
   logic [3*DAC_W-1:0] s3_rgb;

   pal_out_stage #(
      .PAL_W(PAL_W),
      .DAC_W(DAC_W)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (s2_mode),
      .blank_n   (s2_blank_n),
      .entry     (s2_entry),
      .direct_rgb(s2_direct),
      .rgb       (s3_rgb),
      .blank_n_q (blank_n_out)
   );

   assign red_out = s3_rgb[3*DAC_W-1 -: DAC_W];
   assign grn_out = s3_rgb[2*DAC_W-1 -: DAC_W];
   assign blu_out = s3_rgb[DAC_W-1   -: DAC_W];

endmodule

// File: rtl/pal_pixel_pipe_chk.sv
module pal_pixel_pipe_chk #(
   parameter int unsigned PIX_W = 16,
   parameter int unsigned DAC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       pix_mode,
   input logic [PIX_W-1:0] pix_in,
   input logic             blank_n_in,
   input logic [DAC_W-1:0] red_out,
   input logic [DAC_W-1:0] grn_out,
   input logic [DAC_W-1:0] blu_out,
   input logic             blank_n_out
);

   logic [1:0]       age;
   logic [1:0]       d1_mode, d2_mode, d3_mode;
   logic [PIX_W-1:0] d1_pix,  d2_pix,  d3_pix;
   logic             d1_bn,   d2_bn,   d3_bn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age <= '0;
         {d1_mode, d2_mode, d3_mode} <= '0;
         {d1_pix,  d2_pix,  d3_pix}  <= '0;
         {d1_bn,   d2_bn,   d3_bn}   <= '0;
      end else begin
         if (age != 2'd3) age <= age + 2'd1;
         d1_mode <= pix_mode;   d2_mode <= d1_mode; d3_mode <= d2_mode;
         d1_pix  <= pix_in;     d2_pix  <= d1_pix;  d3_pix  <= d2_pix;
         d1_bn   <= blank_n_in; d2_bn   <= d1_bn;   d3_bn   <= d2_bn;
      end
   end

   // R1: outputs cleared while reset is applied
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (!blank_n_out && red_out == '0 && grn_out == '0 && blu_out == '0));

   // R2: blank travels through exactly three stages
   p_blank_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) |-> (blank_n_out == d3_bn));

   // R11: blanked slots carry zero color
   p_blank_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_n_out |-> (red_out == '0 && grn_out == '0 && blu_out == '0));

   // R7: 5-5-5 unpack
   p_rgb555_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && d3_bn && d3_mode == 2'd1) |->
      (red_out == {d3_pix[14:10], {(DAC_W-5){1'b0}}} &&
       grn_out == {d3_pix[9:5],   {(DAC_W-5){1'b0}}} &&
       blu_out == {d3_pix[4:0],   {(DAC_W-5){1'b0}}}));

   // R8: 5-6-5 unpack
   p_rgb565_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && d3_bn && d3_mode == 2'd2) |->
      (red_out == {d3_pix[15:11], {(DAC_W-5){1'b0}}} &&
       grn_out == {d3_pix[10:5],  {(DAC_W-6){1'b0}}} &&
       blu_out == {d3_pix[4:0],   {(DAC_W-5){1'b0}}}));

endmodule

bind pal_pixel_pipe pal_pixel_pipe_chk #(
   .PIX_W(PIX_W),
   .DAC_W(DAC_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pix_mode   (pix_mode),
   .pix_in     (pix_in),
   .blank_n_in (blank_n_in),
   .red_out    (red_out),
   .grn_out    (grn_out),
   .blu_out    (blu_out),
   .blank_n_out(blank_n_out)
);

// File: tb/pal_pixel_pipe_tb.sv
module pal_pixel_pipe_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  pix_mode = 2'd0;
   logic [15:0] pix_in = '0;
   logic        blank_n_in = 1'b0;
   logic        host_we = 1'b0;
   logic        host_sel = 1'b0;
   logic [7:0]  host_addr = '0;
   logic [17:0] host_wdata = '0;
   logic [7:0]  red_out, grn_out, blu_out;
   logic        blank_n_out;

   always #2 clk = ~clk; // 250 MHz

   pal_pixel_pipe u_dut (
      .clk(clk), .rst_n(rst_n), .pix_mode(pix_mode), .pix_in(pix_in),
      .blank_n_in(blank_n_in), .host_we(host_we), .host_sel(host_sel),
      .host_addr(host_addr), .host_wdata(host_wdata),
      .red_out(red_out), .grn_out(grn_out), .blu_out(blu_out),
      .blank_n_out(blank_n_out)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   bit    finished = 0;

   // bench model state
   logic [17:0] pal_m [256];
   logic [7:0]  mask_m = 8'hFF;
   logic        half_m = 1'b0;
   logic [15:0] gb_m = '0;
   logic [23:0] byp_m = '0;

   // expected-value history, three deep
   logic [24:0] h_exp [3];
   string       h_tag [3];
   bit          h_val [3];

   function automatic logic [17:0] pal_pattern(int i);
      logic [5:0] r, g, b;
      r = 6'((i * 5 + 3) & 63);
      g = 6'((i ^ 8'h3C) & 63) ^ 6'(i >> 6);
      b = 6'((255 - i) & 63);
      return {r, g, b};
   endfunction

   task automatic check(logic [24:0] exp, string tag);
      logic [24:0] act;
      act = {red_out, grn_out, blu_out, blank_n_out};
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got rgb=%h blank_n=%b expected rgb=%h blank_n=%b",
                  tag, act[24:1], act[0], exp[24:1], exp[0]);
      end
   endtask

   task automatic step(logic [1:0] m, logic [15:0] p, logic b, string tag);
      logic        second;
      logic [23:0] col;
      logic [17:0] e;
      @(negedge clk);
      if (h_val[2]) check(h_exp[2], h_tag[2]);
      h_exp[2] = h_exp[1]; h_tag[2] = h_tag[1]; h_val[2] = h_val[1];
      h_exp[1] = h_exp[0]; h_tag[1] = h_tag[0]; h_val[1] = h_val[0];
      if (m == 2'd3 && b) begin second = half_m; half_m = ~half_m; end
      else begin second = 1'b0; half_m = 1'b0; end
      col = '0;
      case (m)
         2'd0: begin
            e = pal_m[p[7:0] & mask_m];
            col = {e[17:12], 2'b00, e[11:6], 2'b00, e[5:0], 2'b00};
         end
         2'd1: begin
            byp_m = {p[14:10], 3'b000, p[9:5], 3'b000, p[4:0], 3'b000};
            col = byp_m;
         end
         2'd2: begin
            byp_m = {p[15:11], 3'b000, p[10:5], 2'b00, p[4:0], 3'b000};
            col = byp_m;
         end
         default: begin
            if (second) byp_m = {p[7:0], gb_m};
            else        gb_m  = p;
            col = byp_m;
         end
      endcase
      h_exp[0] = b ? {col, 1'b1} : 25'd0;
      h_tag[0] = tag;
      h_val[0] = 1'b1;
      pix_mode = m; pix_in = p; blank_n_in = b;
   endtask

   task automatic flush();
      for (int k = 0; k < 3; k++) step(2'd0, 16'h0000, 1'b0, "R11");
      h_val[0] = 0; h_val[1] = 0; h_val[2] = 0;
   endtask

   task automatic host_write(logic sel, logic [7:0] a, logic [17:0] d);
      @(negedge clk);
      host_we = 1'b1; host_sel = sel; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
      if (sel) mask_m = d[7:0];
      else     pal_m[a] = d;
   endtask

   initial begin
      h_val[0] = 0; h_val[1] = 0; h_val[2] = 0;
      repeat (3) @(negedge clk);
      check(25'd0, "R1");               // held in reset
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(25'd0, "R1");               // just out of reset

      // R6: load the whole palette with the display blanked
      for (int i = 0; i < 256; i++) host_write(1'b0, 8'(i), pal_pattern(i));
      flush();

      // R1: default mask is all ones, index 0xC3 reaches entry 0xC3
      step(2'd0, 16'h00C3, 1'b1, "R1");
      // R3, R4: every index, upper byte varied
      for (int i = 0; i < 256; i++)
         step(2'd0, {~8'(i * 3), 8'(i)}, 1'b1, "R3,R4");
      // R4: same index, different upper bytes
      for (int i = 0; i < 8; i++) step(2'd0, {8'(i * 37), 8'h5A}, 1'b1, "R4");
      flush();

      // R5: mask values restrict the index
      host_write(1'b1, 8'h00, 18'h0000F);
      for (int i = 0; i < 256; i += 3) step(2'd0, {8'hFF, 8'(i)}, 1'b1, "R5");
      flush();
      host_write(1'b1, 8'h00, 18'h000A5);
      for (int i = 0; i < 256; i++) step(2'd0, 16'(i), 1'b1, "R5");
      flush();
      host_write(1'b1, 8'h00, 18'h000FF);

      // R6: overwrite an entry while blanked, then look it up
      host_write(1'b0, 8'h5A, 18'h2A5C3);
      flush();
      step(2'd0, 16'h005A, 1'b1, "R6");
      step(2'd0, 16'h005B, 1'b1, "R6");
      flush();

      // R7: 5-5-5 sweep including bit 15
      for (int i = 0; i < 600; i++)
         step(2'd1, 16'(i * 16'h9E37 + 16'h1234), 1'b1, "R7");
      // R8: 5-6-5 sweep
      for (int i = 0; i < 600; i++)
         step(2'd2, 16'(i * 16'h6F1B + 16'h0F0F), 1'b1, "R8");

      // R9: 8-8-8 pairs, first-half slots repeat previous color
      flush();
      for (int i = 0; i < 200; i++)
         step(2'd3, 16'(i * 16'h3B5D + 16'h00A7), 1'b1, "R9");

      // R10: blank in mid-pair restarts pairing
      step(2'd3, 16'h1122, 1'b1, "R10");
      step(2'd3, 16'h0033, 1'b0, "R10");
      step(2'd3, 16'h4455, 1'b1, "R10");
      step(2'd3, 16'h0066, 1'b1, "R10");
      // R10: mode change in mid-pair restarts pairing
      step(2'd3, 16'h7788, 1'b1, "R10");
      step(2'd2, 16'hF81F, 1'b1, "R10");
      step(2'd3, 16'h99AA, 1'b1, "R10");
      step(2'd3, 16'h00BB, 1'b1, "R10");
      step(2'd0, 16'h0010, 1'b1, "R10");
      step(2'd3, 16'hCCDD, 1'b1, "R10");
      step(2'd3, 16'h00EE, 1'b1, "R10");

      // R11: irregular blank in every mode
      for (int i = 0; i < 400; i++)
         step(2'(i / 100), 16'(i * 16'h2D4B + 16'h7777),
              ((i * 7) % 5) != 0, "R11");

      // R2: isolated pixel between blanked slots
      flush();
      step(2'd2, 16'hFFFF, 1'b0, "R2");
      step(2'd2, 16'hA5C3, 1'b1, "R2");
      step(2'd2, 16'hFFFF, 1'b0, "R2");
      step(2'd2, 16'hFFFF, 1'b0, "R2");
      flush();

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule